// File: doc/BRIEF.md
# Hashed Page Table Lookup Engine

This engine turns a virtual page number into a physical frame number by walking a hashed page table held in memory. The page number is folded by XOR into a 10-bit bucket index, and the index is added to a table base to find the bucket's head word. The head word points to the first element of a collision chain. The engine visits the elements one after another. For each one it compares the stored page number with the request. When they match, it fetches the frame number and returns it. When the chain ends without a match, or the bucket is empty, it reports a not-found fault.

Each chain element is three consecutive memory words. The word at the element pointer P holds the page number, P+1 holds the frame number, and P+2 holds the pointer to the next element, where zero ends the chain. A hop counter limits how many elements one walk may compare. A corrupted chain that loops back on itself therefore ends in a chain-limit fault instead of hanging the engine. Memory is reached through a read port with a single outstanding request: the engine issues an address pulse and waits for a response strobe.

The walk controller has ten states:
- IDLE: waits for a request.
- HEAD_RD, then HEAD_WT: fetches the bucket head.
- VPN_RD, then VPN_WT: fetches an element's page number.
- NXT_RD, then NXT_WT: fetches the next pointer.
- PFN_RD, then PFN_WT: fetches the frame number.
- DONE: presents the result.

Its transitions are:
- IDLE to HEAD_RD when a request is accepted.
- Each *_RD state to its *_WT state after one cycle.
- HEAD_WT to DONE (empty bucket) or to VPN_RD (head non-zero).
- VPN_WT to PFN_RD (match) or to NXT_RD (mismatch).
- NXT_WT to DONE (zero pointer, or hop limit reached) or back to VPN_RD.
- PFN_WT to DONE.
- DONE to IDLE.

Top module: `hpt_lookup`

## Requirements
- R1: While reset is held and right after it, req_ready is 1, done_valid is 0 and mem_req_valid is 0.
- R2: The first read after a request is accepted goes to tbl_base plus the bucket index. The bucket index is the XOR of the page number's 10-bit slices, which is vpn[9:0] ^ vpn[19:10] for a 20-bit page number.
- R3: If the bucket head word is zero, the walk ends after that single read with res_code 1 (not found).
- R4: For the element at pointer P, the engine reads P (page number), P+2 (next pointer) and P+1 (frame number). It compares the whole page-number word with the zero-extended request, so a word with extra upper bits set does not match. Elements are visited in chain order from the head.
- R5: On a match with the n-th element, the engine reads that element's frame word and finishes with res_code 0. res_pfn equals the low PFN_W bits of the frame word, and exactly 2n+1 reads are made.
- R6: If the n-th element does not match and its next pointer is zero, the walk finishes with res_code 1 after exactly 2n+1 reads.
- R7: At most MAX_HOPS elements are compared per walk. If element MAX_HOPS mismatches and its next pointer is non-zero, the walk finishes with res_code 2 (chain limit) after 2*MAX_HOPS+1 reads. A match on element MAX_HOPS still succeeds.
- R8: mem_req_valid is a one-cycle pulse, and no new read is issued until the previous one has been answered.
- R9: req_ready is 0 from the cycle after acceptance until the result. done_valid is a one-cycle pulse, and req_ready is 1 again in the following cycle.
- R10: res_pfn is zero whenever res_code is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_vpn | input | VPN_W | Virtual page number to translate |
| tbl_base | input | ADDR_W | Word address of bucket-head array, sampled at acceptance |
| done_valid | output | 1 | Result strobe, one cycle |
| res_code | output | 2 | 0 found, 1 not found, 2 chain limit |
| res_pfn | output | PFN_W | Physical frame number, zero on fault |
| mem_req_valid | output | 1 | Read request pulse |
| mem_req_addr | output | ADDR_W | Word address of the read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | DATA_W | Read data word |

## Verification
Lookups are run against a table with several kinds of bucket: a three-deep collision chain, a chain exactly MAX_HOPS long, one a single element longer, a self-referencing element, and empty buckets. Hits at the head, in the middle and at the tail of a chain, and a hit on the last element the hop limit allows, separate correct chain order from early or late termination. The read count checked for each lookup tells a missed element, an extra fetch and an off-by-one in the hop limit apart. Page numbers that share low bits but fold to different buckets, and a stored word with stray upper bits, confirm the hash and the full-width compare. A lookup with a changed table base confirms that the base is added to the bucket index.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HEAD_RD,
        ST_HEAD_WT,
        ST_VPN_RD,
        ST_VPN_WT,
        ST_NXT_RD,
        ST_NXT_WT,
        ST_PFN_RD,
        ST_PFN_WT,
        ST_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        RD_HEAD,
        RD_VPN,
        RD_NEXT,
        RD_PFN
    } rd_sel_e;

    typedef enum logic [1:0] {
        RES_HIT   = 2'd0,
        RES_MISS  = 2'd1,
        RES_LIMIT = 2'd2
    } res_code_e;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
    parameter int VPN_W = 20,
    parameter int IDX_W = 10
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [IDX_W-1:0] idx
);
    localparam int NCHUNK = (VPN_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = NCHUNK * IDX_W;

    logic [PAD_W-1:0] padded;
    assign padded = PAD_W'(vpn);

    always_comb begin
        idx = '0;
        for (int i = 0; i < NCHUNK; i++) begin
            idx = idx ^ padded[i*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/hpt_hop_ctr.sv
module hpt_hop_ctr #(
    parameter int MAX_HOPS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_HOPS + 1);

    logic [CW-1:0] hops_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hops_q <= '0;
        end else if (clr) begin
            hops_q <= CW'(1);
        end else if (inc) begin
            hops_q <= hops_q + CW'(1);
        end
    end

    assign at_limit = (hops_q == CW'(MAX_HOPS));
endmodule

// File: rtl/hpt_walk_fsm.sv
module hpt_walk_fsm
    import hpt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      rsp_valid,
    input  logic      rsp_zero,
    input  logic      vpn_match,
    input  logic      hop_limit,
    output logic      accept,
    output logic      mem_rd,
    output rd_sel_e   rd_sel,
    output logic      ld_ptr,
    output logic      ld_pfn,
    output logic      fin_en,
    output res_code_e fin_code,
    output logic      hop_clr,
    output logic      hop_inc,
    output logic      req_ready,
    output logic      done_valid
);
    walk_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_HEAD_RD;
            ST_HEAD_RD: state_d = ST_HEAD_WT;
            ST_HEAD_WT: if (rsp_valid) state_d = rsp_zero ? ST_DONE : ST_VPN_RD;
            ST_VPN_RD:  state_d = ST_VPN_WT;
            ST_VPN_WT:  if (rsp_valid) state_d = vpn_match ? ST_PFN_RD : ST_NXT_RD;
            ST_NXT_RD:  state_d = ST_NXT_WT;
            ST_NXT_WT:  if (rsp_valid) state_d = (rsp_zero || hop_limit) ? ST_DONE : ST_VPN_RD;
            ST_PFN_RD:  state_d = ST_PFN_WT;
            ST_PFN_WT:  if (rsp_valid) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept     = 1'b0;
        mem_rd     = 1'b0;
        rd_sel     = RD_HEAD;
        ld_ptr     = 1'b0;
        ld_pfn     = 1'b0;
        fin_en     = 1'b0;
        fin_code   = RES_HIT;
        hop_clr    = 1'b0;
        hop_inc    = 1'b0;
        req_ready  = 1'b0;
        done_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                accept    = req_valid;
            end
            ST_HEAD_RD: begin
                mem_rd = 1'b1;
                rd_sel = RD_HEAD;
            end
            ST_HEAD_WT: begin
                if (rsp_valid) begin
                    if (rsp_zero) begin
                        fin_en   = 1'b1;
                        fin_code = RES_MISS;
                    end else begin
                        ld_ptr  = 1'b1;
                        hop_clr = 1'b1;
                    end
                end
            end
            ST_VPN_RD: begin
                mem_rd = 1'b1;
                rd_sel = RD_VPN;
            end
            ST_VPN_WT: ;
            ST_NXT_RD: begin
                mem_rd = 1'b1;
                rd_sel = RD_NEXT;
            end
            ST_NXT_WT: begin
                if (rsp_valid) begin
                    if (rsp_zero) begin
                        fin_en   = 1'b1;
                        fin_code = RES_MISS;
                    end else if (hop_limit) begin
                        fin_en   = 1'b1;
                        fin_code = RES_LIMIT;
                    end else begin
                        ld_ptr  = 1'b1;
                        hop_inc = 1'b1;
                    end
                end
            end
            ST_PFN_RD: begin
                mem_rd = 1'b1;
                rd_sel = RD_PFN;
            end
            ST_PFN_WT: begin
                if (rsp_valid) begin
                    ld_pfn   = 1'b1;
                    fin_en   = 1'b1;
                    fin_code = RES_HIT;
                end
            end
            ST_DONE: done_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/hpt_lookup.sv
module hpt_lookup
    import hpt_pkg::*;
#(
    parameter int VPN_W    = 20,
    parameter int PFN_W    = 20,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 10,
    parameter int MAX_HOPS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ADDR_W-1:0] tbl_base,
    output logic              done_valid,
    output logic [1:0]        res_code,
    output logic [PFN_W-1:0]  res_pfn,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    logic [VPN_W-1:0]  vpn_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [PFN_W-1:0]  pfn_q;
    res_code_e         code_q;

    logic [IDX_W-1:0]  bucket_idx;
    logic              accept, ld_ptr, ld_pfn, fin_en, hop_clr, hop_inc, hop_limit;
    rd_sel_e           rd_sel;
    res_code_e         fin_code;
    logic              rsp_zero, vpn_match;

    assign rsp_zero  = (mem_rsp_data == '0);
    assign vpn_match = (mem_rsp_data == DATA_W'(vpn_q));

    hpt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
        .vpn (vpn_q),
        .idx (bucket_idx)
    );

    hpt_hop_ctr #(.MAX_HOPS(MAX_HOPS)) u_hops (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hop_clr),
        .inc      (hop_inc),
        .at_limit (hop_limit)
    );

    hpt_walk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .rsp_valid  (mem_rsp_valid),
        .rsp_zero   (rsp_zero),
        .vpn_match  (vpn_match),
        .hop_limit  (hop_limit),
        .accept     (accept),
        .mem_rd     (mem_req_valid),
        .rd_sel     (rd_sel),
        .ld_ptr     (ld_ptr),
        .ld_pfn     (ld_pfn),
        .fin_en     (fin_en),
        .fin_code   (fin_code),
        .hop_clr    (hop_clr),
        .hop_inc    (hop_inc),
        .req_ready  (req_ready),
        .done_valid (done_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            base_q <= '0;
            ptr_q  <= '0;
            pfn_q  <= '0;
            code_q <= RES_HIT;
        end else begin
            if (accept) begin
                vpn_q  <= req_vpn;
                base_q <= tbl_base;
                pfn_q  <= '0;
            end
            if (ld_ptr) ptr_q  <= mem_rsp_data[ADDR_W-1:0];
            if (ld_pfn) pfn_q  <= mem_rsp_data[PFN_W-1:0];
            if (fin_en) code_q <= fin_code;
        end
    end

    always_comb begin
        unique case (rd_sel)
            RD_HEAD: mem_req_addr = base_q + ADDR_W'(bucket_idx);
            RD_VPN:  mem_req_addr = ptr_q;
            RD_PFN:  mem_req_addr = ptr_q + ADDR_W'(1);
            RD_NEXT: mem_req_addr = ptr_q + ADDR_W'(2);
            default: mem_req_addr = ptr_q;
        endcase
    end

    assign res_code = code_q;
    assign res_pfn  = pfn_q;
endmodule

// File: rtl/hpt_lookup_chk.sv
module hpt_lookup_chk #(
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VPN_W-1:0]  req_vpn,
    input logic [ADDR_W-1:0] tbl_base,
    input logic              done_valid,
    input logic [1:0]        res_code,
    input logic [PFN_W-1:0]  res_pfn,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid
);
    function automatic logic [IDX_W-1:0] ref_fold(input logic [VPN_W-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int b = 0; b < VPN_W; b++) r[b % IDX_W] = r[b % IDX_W] ^ v[b];
        return r;
    endfunction

    // R2
    bucket_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req_valid &&
            mem_req_addr == $past(tbl_base) + ADDR_W'(ref_fold($past(req_vpn)))));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R8
    no_read_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> !mem_req_valid);

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready));

    // R10
    fault_pfn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && res_code != 2'd0) |-> (res_pfn == '0));

    // R3
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (res_code != 2'd3));
endmodule

bind hpt_lookup hpt_lookup_chk #(
    .VPN_W (VPN_W),
    .PFN_W (PFN_W),
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vpn      (req_vpn),
    .tbl_base     (tbl_base),
    .done_valid   (done_valid),
    .res_code     (res_code),
    .res_pfn      (res_pfn),
    .mem_req_valid(mem_req_valid),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/hpt_lookup_tb.sv
`timescale 1ns/1ps
module hpt_lookup_tb;
    localparam int VPN_W = 20, PFN_W = 20, ADDR_W = 32, DATA_W = 32, IDX_W = 10, MAX_HOPS = 8;
    localparam int LAT = 2;
    localparam logic [31:0] BASE0 = 32'h200;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [VPN_W-1:0]  req_vpn = '0;
    logic [ADDR_W-1:0] tbl_base = BASE0;
    logic              done_valid;
    logic [1:0]        res_code;
    logic [PFN_W-1:0]  res_pfn;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;

    always #2.5 clk = ~clk;

    hpt_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .tbl_base(tbl_base), .done_valid(done_valid),
        .res_code(res_code), .res_pfn(res_pfn), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    logic [31:0] mem [0:2047];
    int          pend_cnt = 0;
    logic [10:0] pend_addr = '0;
    int          reads_total = 0;
    int          overlaps = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (pend_cnt == 1) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem[pend_addr];
            pend_cnt      <= 0;
        end else if (pend_cnt > 1) begin
            pend_cnt <= pend_cnt - 1;
        end
        if (mem_req_valid) begin
            if (pend_cnt != 0) overlaps <= overlaps + 1;
            pend_addr   <= mem_req_addr[10:0];
            pend_cnt    <= LAT;
            reads_total <= reads_total + 1;
        end
    end

    typedef struct packed {
        logic [19:0] vpn;
        logic [1:0]  code;
        logic [19:0] pfn;
        logic [7:0]  reads;
    } vec_t;

    localparam vec_t VECS [0:10] = '{
        '{20'h00807, 2'd0, 20'h33333, 8'd3},
        '{20'h00404, 2'd0, 20'h22222, 8'd5},
        '{20'h00005, 2'd0, 20'h11111, 8'd7},
        '{20'h00C06, 2'd1, 20'h00000, 8'd7},
        '{20'hFFFFF, 2'd0, 20'h44444, 8'd3},
        '{20'h00123, 2'd1, 20'h00000, 8'd1},
        '{20'h00007, 2'd0, 20'h70000, 8'd17},
        '{20'h01C00, 2'd0, 20'h70007, 8'd3},
        '{20'h00009, 2'd2, 20'h00000, 8'd17},
        '{20'h00408, 2'd0, 20'h90001, 8'd17},
        '{20'h00405, 2'd1, 20'h00000, 8'd1}
    };

    function automatic logic [9:0] fold_ref(input logic [19:0] v);
        return v[9:0] ^ v[19:10];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic insert(input logic [19:0] vpn, input logic [19:0] pfn, input int addr);
        int h;
        h = int'(BASE0) + int'(fold_ref(vpn));
        mem[addr]     = {12'h0, vpn};
        mem[addr + 1] = {12'h0, pfn};
        mem[addr + 2] = mem[h];
        mem[h]        = addr;
    endtask

    task automatic lookup(input logic [19:0] vpn, input logic [1:0] code,
                          input logic [19:0] pfn, input int exp_reads);
        int          r0;
        logic [31:0] first_addr;
        bit          got_first, finished;
        int          busy_bad;
        string       tag;
        tag = (code == 2'd2) ? "R7" : (code == 2'd0) ? "R5" : (exp_reads == 1) ? "R3" : "R6";
        @(negedge clk);
        req_valid = 1'b1;
        req_vpn   = vpn;
        r0        = reads_total;
        @(negedge clk);
        req_valid  = 1'b0;
        got_first  = 1'b0;
        finished   = 1'b0;
        busy_bad   = 0;
        first_addr = '0;
        for (int t = 0; t < 1000; t++) begin
            if (mem_req_valid && !got_first) begin
                got_first  = 1'b1;
                first_addr = mem_req_addr;
            end
            if (done_valid) begin
                finished = 1'b1;
                break;
            end
            if (req_ready) busy_bad++;
            @(negedge clk);
        end
        check(finished, "R9 walk finished", 32'(finished), 32'd1);
        if (!finished) return;
        check(busy_bad == 0, "R9 ready low while busy", 32'(busy_bad), 32'd0);
        check(first_addr == tbl_base + 32'(fold_ref(vpn)), "R2 bucket address",
              first_addr, tbl_base + 32'(fold_ref(vpn)));
        check(res_code == code, {tag, " result code"}, 32'(res_code), 32'(code));
        check(res_pfn == pfn, {tag, " frame (R10 on fault)"}, 32'(res_pfn), 32'(pfn));
        check(reads_total - r0 == exp_reads, {tag, " read count (R4)"},
              32'(reads_total - r0), 32'(exp_reads));
        @(negedge clk);
        check(req_ready && !done_valid, "R9 done pulse then ready",
              {30'h0, req_ready, done_valid}, 32'h2);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        insert(20'h00005, 20'h11111, 32'h600);
        insert(20'h00404, 20'h22222, 32'h603);
        insert(20'h00807, 20'h33333, 32'h606);
        insert(20'hFFFFF, 20'h44444, 32'h609);
        for (int k = 0; k < 8; k++)
            insert({k[9:0], 10'd7 ^ k[9:0]}, 20'h70000 + 20'(k), 32'h610 + 3 * k);
        for (int k = 0; k < 9; k++)
            insert({k[9:0], 10'd9 ^ k[9:0]}, 20'h90000 + 20'(k), 32'h630 + 3 * k);
        // self-referencing element in bucket 0x33
        mem[32'h660] = 32'h000FFFFF;
        mem[32'h661] = 32'h00055555;
        mem[32'h662] = 32'h660;
        mem[BASE0 + 32'h33] = 32'h660;
        // element whose stored word has stray upper bits, bucket 0x44
        mem[32'h670] = 32'h80000044;
        mem[32'h671] = 32'h00066666;
        mem[32'h672] = 32'h0;
        mem[BASE0 + 32'h44] = 32'h670;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check(req_ready && !done_valid && !mem_req_valid, "R1 reset state",
              {29'h0, req_ready, done_valid, mem_req_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !done_valid && !mem_req_valid, "R1 after reset",
              {29'h0, req_ready, done_valid, mem_req_valid}, 32'h4);

        for (int v = 0; v < 11; v++)
            lookup(VECS[v].vpn, VECS[v].code, VECS[v].pfn, int'(VECS[v].reads));

        // R7 looping chain is cut at MAX_HOPS elements
        lookup(20'h00033, 2'd2, 20'h0, 2 * MAX_HOPS + 1);
        // R4 full-word compare: stray upper bits do not match
        lookup(20'h00044, 2'd1, 20'h0, 3);
        // R2 changed base: head at 0x400+0x123 is an empty word
        tbl_base = 32'h400;
        lookup(20'h00123, 2'd1, 20'h0, 1);
        tbl_base = BASE0;
        // R5 back-to-back after a base change
        lookup(20'h00404, 2'd0, 20'h22222, 5);

        // R8 no overlapping reads over the whole run
        check(overlaps == 0, "R8 one read outstanding", 32'(overlaps), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule